// File: doc/BRIEF.md
# Fourteen-Source Prioritized Interrupt Controller

This block collects up to thirteen level-sensitive interrupt requests and turns them into a single interrupt level and vector for a processor core. Every source owns an 8-bit control byte. The low five bits of that byte hold an arbitration priority. Bits [4:2] of the same byte are the level handed to the core. Bit 7 selects whether the core receives an autovector or a vector read from a register. A mask register can silence any source, and a pending register shows the live request lines.

Software reaches the block through a simple byte/halfword register port with big-endian lane order. Through that port it can set up the control bytes, the mask, one vector register for the software watchdog, two vector registers for the serial ports, and a reset-cause register whose bits are cleared by writing one. Each cycle the controller works out the winning source. It then registers the level and vector outputs, so a change made through the port shows at the outputs on the following clock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0x3FFE. The control bytes of sources 1..7 read 4 times the source number. Source 8 reads 0x1C, sources 9..11 read 0x80, and sources 12..13 read 0x00. The watchdog vector reads 0x0F, both serial vectors read 0x00, the reset-cause register reads 0x80, and both outputs are 0.
- R2: Pending bit n (halfword at 0x3A, bit 0 always 0) equals request input n. Writes to 0x3A/0x3B have no effect.
- R3: A source with its mask bit at 1 (mask halfword at 0x36, bit n for source n) never wins.
- R4: The unmasked pending source with the largest control bits [4:0] wins. On equal values the lower-numbered source wins.
- R5: If the winning value of bits [4:0] is below 4, or nothing is pending and unmasked, the level and the vector are both 0.
- R6: The level equals the winner's control bits [4:2]. When control bit 7 is 1, the vector is 24 plus the level.
- R7: When control bit 7 is 0, the vector comes from a register. Source 8 uses the watchdog vector (byte 0x42), source 12 the first serial vector (byte 0x44), and source 13 the second serial vector (byte 0x45). Every other source gives 0x0F.
- R8: The reset-cause register at byte 0x40 is cleared bitwise where a write carries ones. No write can set a bit.
- R9: Control bytes sit at 0x14..0x20 (source = offset − 0x13). A halfword access uses the even address, with the even byte in data bits [15:8]. A byte access uses data bits [7:0]. All 16 mask bits are readable and writable.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R11: The level and vector outputs change on the clock edge after the register write or request change that causes them, never on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword, 0 = byte access |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when idle) |
| irq_req | input | 13 | Request lines, bit n is source n |
| irq_level | output | 3 | Registered interrupt level to the core |
| irq_vector | output | 8 | Registered interrupt vector to the core |

## Verification
The bench builds the block with its default fourteen-slot configuration, five-bit priorities and a floor of 4. This makes every source and every priority value small enough to sweep. Each source is driven alone through all 32 priority values with the autovector bit both set and clear. That covers the floor, the level extraction and every vector path. Sweeps of mask patterns and of crafted ties then reach the masking and lower-index tie rules.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // byte offsets of the register port
   localparam int unsigned ICR_ADDR0  = 'h14;  // source 1
   localparam int unsigned MASK_ADDR  = 'h36;
   localparam int unsigned PEND_ADDR  = 'h3A;
   localparam int unsigned RSR_ADDR   = 'h40;
   localparam int unsigned SWV_ADDR   = 'h42;
   localparam int unsigned UV0_ADDR   = 'h44;
   localparam int unsigned UV1_ADDR   = 'h45;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned DATA_W     = 16;
   localparam int unsigned AUTO_BIT   = 7;
   localparam int unsigned LVL_LSB    = 2;

   localparam logic [BYTE_W-1:0] RSR_RST = 8'h80;
   localparam logic [BYTE_W-1:0] SWV_RST = 8'h0F;

   function automatic logic [BYTE_W-1:0] icr_reset(input int unsigned src);
      if (src >= 1 && src <= 7) return BYTE_W'(src * 4);
      else if (src == 8)        return 8'h1C;
      else if (src >= 9 && src <= 11) return 8'h80;
      else                      return 8'h00;
   endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned PRIO_W  = 5
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_en,
   input  logic                              bus_we,
   input  logic                              bus_half,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [DATA_W-1:0]                 bus_wdata,
   output logic [DATA_W-1:0]                 bus_rdata,
   input  logic [NUM_SRC-1:1]                req,
   output logic [NUM_SRC-1:0]                pend_o,
   output logic [NUM_SRC-1:0]                mask_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_o,
   output logic [NUM_SRC-1:0]                auto_o,
   output logic [BYTE_W-1:0]                 swv_o,
   output logic [BYTE_W-1:0]                 uv0_o,
   output logic [BYTE_W-1:0]                 uv1_o
);
   localparam logic [DATA_W-1:0] MASK_RST = DATA_W'((32'd1 << NUM_SRC) - 32'd2);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_ADDR);
   localparam logic [ADDR_W-1:0] A_MASK1 = ADDR_W'(MASK_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(PEND_ADDR);
   localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'(PEND_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_RSR   = ADDR_W'(RSR_ADDR);
   localparam logic [ADDR_W-1:0] A_SWV   = ADDR_W'(SWV_ADDR);
   localparam logic [ADDR_W-1:0] A_UV0   = ADDR_W'(UV0_ADDR);
   localparam logic [ADDR_W-1:0] A_UV1   = ADDR_W'(UV1_ADDR);

   logic [BYTE_W-1:0] icr_q [1:NUM_SRC-1];
   logic [DATA_W-1:0] mask_q;
   logic [BYTE_W-1:0] rsr_q, swv_q, uv0_q, uv1_q;
   logic [DATA_W-1:0] pend16;

   // byte lanes: lane 0 is the addressed (or even) byte, lane 1 the odd byte of a halfword
   logic [ADDR_W-1:0] a0, a1;
   logic [BYTE_W-1:0] d0, d1;
   logic              w0, w1;

   always_comb begin
      a0 = bus_half ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
      a1 = {a0[ADDR_W-1:1], 1'b1};
      d0 = bus_half ? bus_wdata[DATA_W-1:BYTE_W] : bus_wdata[BYTE_W-1:0];
      d1 = bus_wdata[BYTE_W-1:0];
      w0 = bus_en & bus_we;
      w1 = bus_en & bus_we & bus_half;
   end

   assign pend_o = {req, 1'b0};

   always_comb begin
      pend16 = '0;
      pend16[NUM_SRC-1:0] = pend_o;
   end

   function automatic logic [BYTE_W-1:0] merge(input logic [ADDR_W-1:0] at,
                                               input logic [BYTE_W-1:0] old);
      logic [BYTE_W-1:0] r;
      r = old;
      if (w0 && a0 == at) r = d0;
      if (w1 && a1 == at) r = d1;
      return r;
   endfunction

   function automatic logic [BYTE_W-1:0] clr_bits(input logic [ADDR_W-1:0] at);
      logic [BYTE_W-1:0] r;
      r = '0;
      if (w0 && a0 == at) r = r | d0;
      if (w1 && a1 == at) r = r | d1;
      return r;
   endfunction

   function automatic logic [BYTE_W-1:0] rd_byte(input logic [ADDR_W-1:0] at);
      logic [BYTE_W-1:0] r;
      r = '0;
      for (int s = 1; s < NUM_SRC; s++)
         if (at == ADDR_W'(ICR_ADDR0 + s - 1)) r = icr_q[s];
      if (at == A_MASK)  r = mask_q[DATA_W-1:BYTE_W];
      if (at == A_MASK1) r = mask_q[BYTE_W-1:0];
      if (at == A_PEND)  r = pend16[DATA_W-1:BYTE_W];
      if (at == A_PEND1) r = pend16[BYTE_W-1:0];
      if (at == A_RSR)   r = rsr_q;
      if (at == A_SWV)   r = swv_q;
      if (at == A_UV0)   r = uv0_q;
      if (at == A_UV1)   r = uv1_q;
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 1; s < NUM_SRC; s++) icr_q[s] <= icr_reset(s);
         mask_q <= MASK_RST;
         rsr_q  <= RSR_RST;
         swv_q  <= SWV_RST;
         uv0_q  <= '0;
         uv1_q  <= '0;
      end else begin
         for (int s = 1; s < NUM_SRC; s++)
            icr_q[s] <= merge(ADDR_W'(ICR_ADDR0 + s - 1), icr_q[s]);
         mask_q <= {merge(A_MASK, mask_q[DATA_W-1:BYTE_W]), merge(A_MASK1, mask_q[BYTE_W-1:0])};
         rsr_q  <= rsr_q & ~clr_bits(A_RSR);
         swv_q  <= merge(A_SWV, swv_q);
         uv0_q  <= merge(A_UV0, uv0_q);
         uv1_q  <= merge(A_UV1, uv1_q);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we)
         bus_rdata = bus_half ? {rd_byte(a0), rd_byte(a1)} : {{BYTE_W{1'b0}}, rd_byte(a0)};
   end

   always_comb begin
      prio_o = '0;
      auto_o = '0;
      for (int s = 1; s < NUM_SRC; s++) begin
         prio_o[s] = icr_q[s][PRIO_W-1:0];
         auto_o[s] = icr_q[s][AUTO_BIT];
      end
   end

   assign mask_o = mask_q[NUM_SRC-1:0];
   assign swv_o  = swv_q;
   assign uv0_o  = uv0_q;
   assign uv1_o  = uv1_q;

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && bus_we) |=> $stable(mask_q));

   // R8
   rsr_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsr_q & ~$past(rsr_q)) == '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 14,
   parameter int unsigned PRIO_W    = 5,
   parameter int unsigned MIN_PRIO  = 4,
   parameter int unsigned AUTO_BASE = 24,
   parameter int unsigned SWV_SRC   = 8,
   parameter int unsigned UV0_SRC   = 12,
   parameter int unsigned UV1_SRC   = 13,
   parameter logic [7:0]  DEF_VEC   = 8'h0F,
   localparam int unsigned SRC_W    = $clog2(NUM_SRC),
   localparam int unsigned LVL_W    = PRIO_W - LVL_LSB
) (
   input  logic [NUM_SRC-1:0]             pend,
   input  logic [NUM_SRC-1:0]             mask,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input  logic [NUM_SRC-1:0]             auto_av,
   input  logic [BYTE_W-1:0]              swv,
   input  logic [BYTE_W-1:0]              uv0,
   input  logic [BYTE_W-1:0]              uv1,
   output logic [LVL_W-1:0]               level,
   output logic [BYTE_W-1:0]              vector,
   output logic [SRC_W-1:0]               win
);
   logic [PRIO_W-1:0] best_p;
   logic [SRC_W-1:0]  best;

   always_comb begin
      best_p = '0;
      best   = '0;
      // strict compare: ascending scan keeps the lower index on ties
      for (int s = 0; s < NUM_SRC; s++) begin
         if (pend[s] && !mask[s] && prio[s] > best_p) begin
            best_p = prio[s];
            best   = SRC_W'(s);
         end
      end
      level  = '0;
      vector = '0;
      win    = '0;
      if (best_p >= PRIO_W'(MIN_PRIO)) begin
         win   = best;
         level = best_p[PRIO_W-1:LVL_LSB];
         if (auto_av[best])                  vector = BYTE_W'(AUTO_BASE) + BYTE_W'(level);
         else if (best == SRC_W'(SWV_SRC))   vector = swv;
         else if (best == SRC_W'(UV0_SRC))   vector = uv0;
         else if (best == SRC_W'(UV1_SRC))   vector = uv1;
         else                                vector = DEF_VEC;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 14,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PRIO_W    = 5,
   parameter int unsigned MIN_PRIO  = 4,
   parameter int unsigned AUTO_BASE = 24,
   parameter int unsigned SWV_SRC   = 8,
   parameter int unsigned UV0_SRC   = 12,
   parameter int unsigned UV1_SRC   = 13,
   parameter logic [7:0]  DEF_VEC   = 8'h0F,
   localparam int unsigned SRC_W    = $clog2(NUM_SRC),
   localparam int unsigned LVL_W    = PRIO_W - LVL_LSB
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic                 bus_half,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          bus_rdata,
   input  logic [NUM_SRC-1:1]   irq_req,
   output logic [LVL_W-1:0]     irq_level,
   output logic [7:0]           irq_vector
);
   if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must lie in 2..16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the register map");
   end
   if (PRIO_W <= LVL_LSB || PRIO_W > AUTO_BIT) begin : g_bad_prio
      $error("PRIO_W must fit below the autovector bit");
   end
   if (MIN_PRIO >= (1 << PRIO_W)) begin : g_bad_floor
      $error("MIN_PRIO exceeds the priority range");
   end
   if (SWV_SRC >= NUM_SRC || UV0_SRC >= NUM_SRC || UV1_SRC >= NUM_SRC) begin : g_bad_vsrc
      $error("vector-register source outside the source range");
   end

   logic [NUM_SRC-1:0]             pend_w, mask_w, auto_w;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
   logic [BYTE_W-1:0]              swv_w, uv0_w, uv1_w;
   logic [LVL_W-1:0]               arb_level, lvl_q;
   logic [BYTE_W-1:0]              arb_vec, vec_q;
   logic [SRC_W-1:0]               arb_win;

   irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_half(bus_half),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req(irq_req),
      .pend_o(pend_w), .mask_o(mask_w), .prio_o(prio_w), .auto_o(auto_w),
      .swv_o(swv_w), .uv0_o(uv0_w), .uv1_o(uv1_w)
   );

   irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MIN_PRIO(MIN_PRIO), .AUTO_BASE(AUTO_BASE),
                 .SWV_SRC(SWV_SRC), .UV0_SRC(UV0_SRC), .UV1_SRC(UV1_SRC), .DEF_VEC(DEF_VEC)) arb_i (
      .pend(pend_w), .mask(mask_w), .prio(prio_w), .auto_av(auto_w),
      .swv(swv_w), .uv0(uv0_w), .uv1(uv1_w),
      .level(arb_level), .vector(arb_vec), .win(arb_win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         vec_q <= '0;
      end else begin
         lvl_q <= arb_level;
         vec_q <= arb_vec;
      end
   end

   assign irq_level  = lvl_q;
   assign irq_vector = vec_q;

   // R5
   lvl_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == '0) |-> (irq_vector == '0));

   // R3
   winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_level != '0) |-> (pend_w[arb_win] && !mask_w[arb_win]));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/100ps
module irq_prio_ctrl_tb_top;
   logic        clk, rst_n, bus_en, bus_we, bus_half;
   logic [7:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [13:1] irq_req;
   logic [2:0]  irq_level;
   logic [7:0]  irq_vector;
   int n_chk = 0;
   int n_err = 0;

   irq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_half(bus_half),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic h);
      @(negedge clk);
      bus_en = 1; bus_we = 1; bus_half = h; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic h, output logic [15:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 0; bus_half = h; bus_addr = a;
      #1 d = bus_rdata;
      bus_en = 0;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_out(input string tag, input int el, input int ev);
      chk({tag, " level"}, int'(irq_level), el);
      chk({tag, " vector"}, int'(irq_vector), ev);
   endtask

   function automatic int icr_rst(input int s);
      if (s < 8) return 4 * s;
      if (s == 8) return 'h1C;
      if (s < 12) return 'h80;
      return 0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] d;
      rst_n = 0; bus_en = 0; bus_we = 0; bus_half = 0; bus_addr = '0; bus_wdata = '0; irq_req = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      for (int s = 1; s <= 13; s++) begin
         rd(8'(8'h13 + s), 0, d);
         chk("R1 control reset", int'(d), icr_rst(s));
      end
      rd(8'h36, 1, d); chk("R1 mask reset", int'(d), 'h3FFE);
      rd(8'h40, 0, d); chk("R1 reset-cause reset", int'(d), 'h80);
      rd(8'h42, 0, d); chk("R1 watchdog vector reset", int'(d), 'h0F);
      rd(8'h44, 1, d); chk("R1 serial vectors reset", int'(d), 0);
      chk_out("R1 outputs", 0, 0);

      // R7 vector registers
      wr(8'h42, 16'h005A, 0);
      wr(8'h44, 16'h0061, 0);
      wr(8'h45, 16'h0062, 0);
      rd(8'h44, 1, d); chk("R7 serial vectors", int'(d), 'h6162);
      rd(8'h42, 0, d); chk("R7 watchdog vector", int'(d), 'h5A);

      // R5 R6 R7: each source alone through every priority and both vector modes
      wr(8'h36, 16'h0000, 1);
      for (int s = 1; s <= 13; s++) begin
         irq_req = '0;
         irq_req[s] = 1'b1;
         for (int p = 0; p < 32; p++) begin
            for (int av = 0; av < 2; av++) begin
               int el, ev;
               wr(8'(8'h13 + s), 16'(av * 128 + p), 0);
               settle();
               el = (p < 4) ? 0 : p / 4;
               if (p < 4)       ev = 0;
               else if (av == 1) ev = 24 + el;
               else if (s == 8)  ev = 'h5A;
               else if (s == 12) ev = 'h61;
               else if (s == 13) ev = 'h62;
               else              ev = 'h0F;
               chk_out((p < 4) ? "R5" : ((av == 1) ? "R6" : "R7"), el, ev);
            end
         end
      end

      // R3 masking: all pending, priority s+3, only 1..k unmasked
      irq_req = '1;
      for (int s = 1; s <= 13; s++) wr(8'(8'h13 + s), 16'(8'h80 + s + 3), 0);
      for (int k = 13; k >= 1; k--) begin
         wr(8'h36, 16'(~((32'd1 << (k + 1)) - 32'd2)), 1);
         settle();
         chk_out("R3 mask sweep", (k + 3) / 4, 24 + (k + 3) / 4);
      end
      wr(8'h36, 16'hFFFF, 1);
      settle();
      chk_out("R3 all masked", 0, 0);

      // R4 ties and ordering, R11 latency
      for (int s = 1; s <= 13; s++) wr(8'(8'h13 + s), 16'h0000, 0);
      wr(8'h36, 16'h0000, 1);
      settle();
      chk_out("R5 all zero priority", 0, 0);
      wr(8'h1F, 16'h0010, 0);
      chk_out("R11 same-edge hold", 0, 0);
      settle();
      chk_out("R11 next-edge update", 4, 'h61);
      wr(8'h1B, 16'h0010, 0);
      settle();
      chk_out("R4 tie lower index", 4, 'h5A);
      wr(8'h20, 16'h0014, 0);
      settle();
      chk_out("R4 higher priority", 5, 'h62);
      wr(8'h14, 16'h0014, 0);
      settle();
      chk_out("R4 tie source 1 default vector R7", 5, 'h0F);
      wr(8'h37, 16'h0002, 0);
      settle();
      chk_out("R3 byte mask of source 1", 5, 'h62);
      rd(8'h36, 1, d); chk("R9 byte lane mask", int'(d), 'h0002);
      irq_req[13] = 1'b0;
      settle();
      chk_out("R2 request drop", 4, 'h5A);

      // R9 lane order
      wr(8'h14, 16'h1234, 1);
      rd(8'h14, 0, d); chk("R9 even byte", int'(d), 'h12);
      rd(8'h15, 0, d); chk("R9 odd byte", int'(d), 'h34);
      rd(8'h14, 1, d); chk("R9 halfword read", int'(d), 'h1234);
      wr(8'h36, 16'hA55A, 1);
      rd(8'h36, 0, d); chk("R9 mask high byte", int'(d), 'hA5);
      rd(8'h37, 0, d); chk("R9 mask low byte", int'(d), 'h5A);
      wr(8'h37, 16'h0102, 1);
      rd(8'h36, 1, d); chk("R9 odd halfword aligns down", int'(d), 'h0102);

      // R10 unmapped space
      rd(8'h00, 1, d); chk("R10 read 0x00", int'(d), 0);
      rd(8'h13, 0, d); chk("R10 read 0x13", int'(d), 0);
      rd(8'h21, 0, d); chk("R10 read 0x21", int'(d), 0);
      rd(8'h46, 1, d); chk("R10 read 0x46", int'(d), 0);
      rd(8'hFF, 0, d); chk("R10 read 0xFF", int'(d), 0);
      wr(8'h21, 16'h00FF, 0);
      wr(8'h43, 16'h00FF, 0);
      wr(8'h46, 16'hFFFF, 1);
      rd(8'h20, 0, d); chk("R10 neighbour control", int'(d), 'h14);
      rd(8'h42, 0, d); chk("R10 neighbour watchdog vector", int'(d), 'h5A);
      rd(8'h44, 1, d); chk("R10 neighbour serial vectors", int'(d), 'h6162);

      // R2 pending view
      irq_req = 13'h1555;
      rd(8'h3A, 1, d); chk("R2 pending", int'(d), 'h2AAA);
      wr(8'h3A, 16'h0000, 1);
      rd(8'h3A, 1, d); chk("R2 pending write ignored", int'(d), 'h2AAA);
      rd(8'h3B, 0, d); chk("R2 pending low byte", int'(d), 'hAA);

      // R8 reset-cause write-one-to-clear
      wr(8'h40, 16'h007F, 0);
      rd(8'h40, 0, d); chk("R8 zero bits keep", int'(d), 'h80);
      wr(8'h40, 16'h0080, 0);
      rd(8'h40, 0, d); chk("R8 one bit clears", int'(d), 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule